// File: doc/BRIEF.md
# NAND bus operation decoder

This block is the device-side front end of a parallel NAND flash pin interface. It runs on a fast internal clock and samples the raw control pins: chip select, command latch, address latch, write strobe, read strobe and write protect, plus an IO bus of up to 16 bits. It works out what each write strobe means from the levels around it and reports it on simple internal ports. A strobe can be a command byte, one byte of a multi-cycle address, or one data word bound for the page buffer. It also drives one output word for each read strobe, taken from the page-buffer read port or from one of three small byte sources: status, lock state or identification.

Both strobes and chip select pass through a two-flop synchronizer and a persistence filter, so short pulses never become bus cycles. Write protect is synchronized and used at the moment it matters, never held, so a protect input held low at power-up blocks every modifying operation. Command and address bytes always come from the low eight IO lines. A configuration input selects 8- or 16-bit data words.

Top module: `nand_bus_front`

## Requirements
- R1: A filtered rising write strobe with chip select low, command latch high, address latch low and read strobe high pulses `cmd_valid` once, with `cmd_byte` equal to IO[7:0]. The upper IO lines are ignored even in 16-bit mode.
- R2: Four address strobes (address latch high, command latch low, chip select low, read strobe high) assemble the address. The first byte lands in bits 7:0, the second in 15:8, the third in 23:16, and bits 26:24 come from the fourth byte. `addr_valid` pulses once after the fourth byte, and `addr` then holds.
- R3: Address strobes after the fourth are ignored. A command strobe restarts the byte count, so a partial address followed by a command is dropped.
- R4: A write strobe with chip select, command latch and address latch low, and read strobe and write protect high, pulses `wr_valid`. `wr_data` is the full IO word in 16-bit mode and IO[7:0] zero-extended in 8-bit mode.
- R5: While write protect is low, data-input strobes produce no `wr_valid`.
- R6: Commands 80h (program) and 60h (erase) pulse `modify_start` when write protect is high and `modify_refused` when it is low. Both still pulse `cmd_valid`.
- R7: Each filtered falling read strobe with chip select low, write strobe high and both latches low loads one word into `io_out`. With the array as source it pulses `rd_req` once and takes `rd_data`: the full word in 16-bit mode, the low byte zero-extended in 8-bit mode.
- R8: The last command picks the read source: 70h status, 90h identification, 7Ah lock state, any other code the array. The byte sources are zero-extended and never pulse `rd_req`.
- R9: A low pulse on the write or read strobe that lasts fewer than FILT_LEN (default 3) clock samples produces no bus cycle and no output word.
- R10: With chip select high no bus cycle is decoded and `io_oe` stays low.
- R11: `io_oe` is high only while chip select and the read strobe are both low after filtering.
- R12: After reset every pulse output is low, `io_oe` is low and `addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_x16 | input | 1 | 1 selects 16-bit data words, 0 selects 8-bit |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low, captures on rising edge |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | IO_W | IO bus as seen at the pins |
| io_out | output | IO_W | Word driven onto the IO bus |
| io_oe | output | 1 | Output enable for the IO drivers |
| cmd_valid | output | 1 | One-cycle pulse per accepted command |
| cmd_byte | output | 8 | Last command byte |
| addr_valid | output | 1 | One-cycle pulse when the address is complete |
| addr | output | ADDR_W | Assembled address |
| wr_valid | output | 1 | Page-buffer write pulse |
| wr_data | output | IO_W | Page-buffer write word |
| modify_start | output | 1 | Program or erase command accepted |
| modify_refused | output | 1 | Program or erase command blocked by protect |
| rd_req | output | 1 | Page-buffer read advance pulse |
| rd_data | input | IO_W | Page-buffer read word, valid while rd_req is high |
| status_in | input | 8 | Status byte source |
| id_in | input | 8 | Identification byte source |
| lock_in | input | 8 | Lock state byte source |

## Verification
The bench goes after strobes that should be ignored. It sends two-sample pulses on write and read, write pulses with chip select high, a fifth address byte and a partial address cut off by a command. A decoder with a weak filter or a missing chip select gate would report stray command pulses. One without a restart or cap on the byte count would move `addr` or pulse `addr_valid` at the wrong time. The bench toggles write protect around program and erase commands and around data words, where a latched or ignored protect would start a modify or write the page buffer. It also reads in both widths and from each byte source, where a wrong mux or lane choice shows as a wrong `io_out` value or an extra `rd_req`.

// File: rtl/nfb_pkg.sv
package nfb_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_ID     = 2'd2,
    SRC_LOCK   = 2'd3
  } rd_src_e;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2,
    CYC_DIN  = 2'd3
  } cyc_e;

  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_LOCK   = 8'h7A;
  localparam logic [7:0] OP_PROG   = 8'h80;
  localparam logic [7:0] OP_ERASE  = 8'h60;

  function automatic rd_src_e src_for_op(input logic [7:0] op);
    rd_src_e s;
    case (op)
      OP_STATUS: s = SRC_STATUS;
      OP_IDENT:  s = SRC_ID;
      OP_LOCK:   s = SRC_LOCK;
      default:   s = SRC_ARRAY;
    endcase
    return s;
  endfunction

  function automatic logic op_modifies(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_ERASE);
  endfunction

endpackage

// File: rtl/nfb_sync.sv
module nfb_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/nfb_pin_filter.sv
module nfb_pin_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);

  localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

  logic             sync_lvl;
  logic             level_q, level_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  nfb_sync #(.W(1), .RST_VAL(RST_VAL)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (sync_lvl)
  );

  // a new level must persist for FILT_LEN consecutive samples
  always_comb begin
    level_n = level_q;
    cnt_n   = '0;
    if (sync_lvl != level_q) begin
      if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        level_n = sync_lvl;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= RST_VAL;
      cnt_q   <= '0;
    end else begin
      level_q <= level_n;
      cnt_q   <= cnt_n;
    end
  end

  assign level = level_q;

  generate
    if (FILT_LEN >= 2) begin : g_hold_chk
      // R9: a filtered level never changes on two consecutive cycles
      a_r9_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |=> (level_q == $past(level_q)));
    end
  endgenerate

endmodule

// File: rtl/nfb_cycle_decode.sv
module nfb_cycle_decode
  import nfb_pkg::*;
#(
  parameter int IO_W       = 16,
  parameter int ADDR_W     = 27,
  parameter int ADDR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_x16,
  input  logic              ce_f,
  input  logic              we_f,
  input  logic              re_f,
  input  logic              cle_s,
  input  logic              ale_s,
  input  logic              wp_s,
  input  logic [IO_W-1:0]   io_s,
  output logic              cmd_valid,
  output logic [7:0]        cmd_byte,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_valid,
  output logic [IO_W-1:0]   wr_data,
  output logic              modify_start,
  output logic              modify_refused,
  output rd_src_e           rd_src
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic              we_d_q;
  logic              we_rise;
  cyc_e              cyc;

  logic              cmd_valid_q, cmd_valid_n;
  logic [7:0]        cmd_byte_q, cmd_byte_n;
  logic              addr_valid_q, addr_valid_n;
  logic [ADDR_W-1:0] stage_q, stage_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              wr_valid_q, wr_valid_n;
  logic [IO_W-1:0]   wr_data_q, wr_data_n;
  logic              mstart_q, mstart_n;
  logic              mref_q, mref_n;
  rd_src_e           src_q, src_n;

  assign we_rise = we_f & ~we_d_q;

  // cycle classification from the levels around the write strobe
  always_comb begin
    cyc = CYC_IDLE;
    if (we_rise && !ce_f && re_f) begin
      case ({cle_s, ale_s})
        2'b10:   cyc = CYC_CMD;
        2'b01:   cyc = CYC_ADDR;
        2'b00:   cyc = wp_s ? CYC_DIN : CYC_IDLE;
        default: cyc = CYC_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid_n  = 1'b0;
    addr_valid_n = 1'b0;
    wr_valid_n   = 1'b0;
    mstart_n     = 1'b0;
    mref_n       = 1'b0;
    cmd_byte_n   = cmd_byte_q;
    stage_n      = stage_q;
    cnt_n        = cnt_q;
    wr_data_n    = wr_data_q;
    src_n        = src_q;
    case (cyc)
      CYC_CMD: begin
        cmd_valid_n = 1'b1;
        cmd_byte_n  = io_s[7:0];
        cnt_n       = '0;
        src_n       = src_for_op(io_s[7:0]);
        if (op_modifies(io_s[7:0])) begin
          mstart_n = wp_s;
          mref_n   = ~wp_s;
        end
      end
      CYC_ADDR: begin
        if (cnt_q < CNT_W'(ADDR_BYTES)) begin
          if (cnt_q == '0) stage_n = '0;
          for (int k = 0; k < ADDR_BYTES; k++) begin
            if (cnt_q == CNT_W'(k)) begin
              for (int b = 0; b < 8; b++) begin
                if (8 * k + b < ADDR_W) stage_n[8 * k + b] = io_s[b];
              end
            end
          end
          cnt_n = cnt_q + CNT_W'(1);
          addr_valid_n = (cnt_q == CNT_W'(ADDR_BYTES - 1));
        end
      end
      CYC_DIN: begin
        wr_valid_n = 1'b1;
        wr_data_n  = cfg_x16 ? io_s : IO_W'(io_s[7:0]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_d_q       <= 1'b1;
      cmd_valid_q  <= 1'b0;
      cmd_byte_q   <= '0;
      addr_valid_q <= 1'b0;
      stage_q      <= '0;
      cnt_q        <= '0;
      wr_valid_q   <= 1'b0;
      wr_data_q    <= '0;
      mstart_q     <= 1'b0;
      mref_q       <= 1'b0;
      src_q        <= SRC_ARRAY;
    end else begin
      we_d_q       <= we_f;
      cmd_valid_q  <= cmd_valid_n;
      cmd_byte_q   <= cmd_byte_n;
      addr_valid_q <= addr_valid_n;
      stage_q      <= stage_n;
      cnt_q        <= cnt_n;
      wr_valid_q   <= wr_valid_n;
      wr_data_q    <= wr_data_n;
      mstart_q     <= mstart_n;
      mref_q       <= mref_n;
      src_q        <= src_n;
    end
  end

  assign cmd_valid      = cmd_valid_q;
  assign cmd_byte       = cmd_byte_q;
  assign addr_valid     = addr_valid_q;
  assign addr           = stage_q;
  assign wr_valid       = wr_valid_q;
  assign wr_data        = wr_data_q;
  assign modify_start   = mstart_q;
  assign modify_refused = mref_q;
  assign rd_src         = src_q;

  // R2: the completed address holds once it has been reported
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_q |=> $stable(stage_q));

endmodule

// File: rtl/nfb_read_port.sv
module nfb_read_port
  import nfb_pkg::*;
#(
  parameter int IO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_x16,
  input  logic            ce_f,
  input  logic            we_f,
  input  logic            re_f,
  input  logic            cle_s,
  input  logic            ale_s,
  input  rd_src_e         rd_src,
  input  logic [IO_W-1:0] rd_data,
  input  logic [7:0]      status_in,
  input  logic [7:0]      id_in,
  input  logic [7:0]      lock_in,
  output logic            rd_req,
  output logic [IO_W-1:0] io_out,
  output logic            io_oe
);

  logic            re_d_q;
  logic            take;
  logic [IO_W-1:0] word;
  logic [IO_W-1:0] io_q, io_n;

  assign take = ~re_f & re_d_q & ~ce_f & we_f & ~cle_s & ~ale_s;

  always_comb begin
    case (rd_src)
      SRC_STATUS: word = IO_W'(status_in);
      SRC_ID:     word = IO_W'(id_in);
      SRC_LOCK:   word = IO_W'(lock_in);
      default:    word = cfg_x16 ? rd_data : IO_W'(rd_data[7:0]);
    endcase
    io_n = take ? word : io_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_d_q <= 1'b1;
      io_q   <= '0;
    end else begin
      re_d_q <= re_f;
      io_q   <= io_n;
    end
  end

  assign rd_req = take & (rd_src == SRC_ARRAY);
  assign io_out = io_q;
  assign io_oe  = ~ce_f & ~re_f;

  // R7: the page buffer is advanced only when it is the selected source
  a_r7_req_array_only: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_src == SRC_ARRAY));

endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front
  import nfb_pkg::*;
#(
  parameter int IO_W       = 16,
  parameter int ADDR_W     = 27,
  parameter int ADDR_BYTES = 4,
  parameter int FILT_LEN   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_x16,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              we_n,
  input  logic              re_n,
  input  logic              wp_n,
  input  logic [IO_W-1:0]   io_in,
  output logic [IO_W-1:0]   io_out,
  output logic              io_oe,
  output logic              cmd_valid,
  output logic [7:0]        cmd_byte,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_valid,
  output logic [IO_W-1:0]   wr_data,
  output logic              modify_start,
  output logic              modify_refused,
  output logic              rd_req,
  input  logic [IO_W-1:0]   rd_data,
  input  logic [7:0]        status_in,
  input  logic [7:0]        id_in,
  input  logic [7:0]        lock_in
);

  localparam int N_STRB = 3;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [N_STRB-1:0] strb_raw;
  logic [N_STRB-1:0] strb_f;
  logic              ce_f, we_f, re_f;
  logic [2:0]        lvl_s;
  logic              cle_s, ale_s, wp_s;
  logic [IO_W-1:0]   io_s;
  rd_src_e           rd_src;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign strb_raw = {re_n, we_n, ce_n};

  generate
    for (genvar i = 0; i < N_STRB; i++) begin : g_strb
      nfb_pin_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
        .clk   (clk),
        .rst_n (rst_int_n),
        .raw   (strb_raw[i]),
        .level (strb_f[i])
      );
    end
  endgenerate

  assign ce_f = strb_f[0];
  assign we_f = strb_f[1];
  assign re_f = strb_f[2];

  // protect resets to the protected state and is never latched
  nfb_sync #(.W(3), .RST_VAL(3'b000)) u_lvl_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({wp_n, ale, cle}),
    .q     (lvl_s)
  );
  assign cle_s = lvl_s[0];
  assign ale_s = lvl_s[1];
  assign wp_s  = lvl_s[2];

  nfb_sync #(.W(IO_W), .RST_VAL('0)) u_io_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (io_in),
    .q     (io_s)
  );

  nfb_cycle_decode #(.IO_W(IO_W), .ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES)) u_decode (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .cfg_x16        (cfg_x16),
    .ce_f           (ce_f),
    .we_f           (we_f),
    .re_f           (re_f),
    .cle_s          (cle_s),
    .ale_s          (ale_s),
    .wp_s           (wp_s),
    .io_s           (io_s),
    .cmd_valid      (cmd_valid),
    .cmd_byte       (cmd_byte),
    .addr_valid     (addr_valid),
    .addr           (addr),
    .wr_valid       (wr_valid),
    .wr_data        (wr_data),
    .modify_start   (modify_start),
    .modify_refused (modify_refused),
    .rd_src         (rd_src)
  );

  nfb_read_port #(.IO_W(IO_W)) u_read (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_x16   (cfg_x16),
    .ce_f      (ce_f),
    .we_f      (we_f),
    .re_f      (re_f),
    .cle_s     (cle_s),
    .ale_s     (ale_s),
    .rd_src    (rd_src),
    .rd_data   (rd_data),
    .status_in (status_in),
    .id_in     (id_in),
    .lock_in   (lock_in),
    .rd_req    (rd_req),
    .io_out    (io_out),
    .io_oe     (io_oe)
  );

  // R10: a deselected device never drives the bus
  a_r10_standby_no_drive: assert property (@(posedge clk) disable iff (!rst_int_n)
    ce_f |-> !io_oe);

  // R10: every decoded cycle comes from a selected device
  a_r10_standby_no_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid || addr_valid || wr_valid) |-> !$past(ce_f));

  // R5: page-buffer writes only with protect released
  a_r5_din_needs_wp: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_valid |-> $past(wp_s));

  // R6: a modify start only with protect released
  a_r6_modify_needs_wp: assert property (@(posedge clk) disable iff (!rst_int_n)
    modify_start |-> ($past(wp_s) && cmd_valid));

endmodule

// File: tb/test_nand_bus_front.sv
module test_nand_bus_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_x16 = 1'b0;
  logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic        we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [15:0] io_in = '0;
  logic [15:0] io_out;
  logic        io_oe;
  logic        cmd_valid, addr_valid, wr_valid;
  logic [7:0]  cmd_byte;
  logic [26:0] addr;
  logic [15:0] wr_data;
  logic        modify_start, modify_refused, rd_req;
  logic [15:0] rd_data;
  logic [15:0] rd_cnt;

  always #4 clk = ~clk;

  nand_bus_front i_nand_bus_front (
    .clk(clk), .rst_n(rst_n), .cfg_x16(cfg_x16),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .wp_n(wp_n),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .addr_valid(addr_valid), .addr(addr),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .modify_start(modify_start), .modify_refused(modify_refused),
    .rd_req(rd_req), .rd_data(rd_data),
    .status_in(8'hE0), .id_in(8'hAD), .lock_in(8'h05)
  );

  // page buffer model: word index advances on each read request
  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd_cnt <= '0;
    else if (rd_req) rd_cnt <= rd_cnt + 16'd1;
  assign rd_data = 16'hA000 + rd_cnt;

  int n_chk = 0, n_fail = 0;
  int seen_cmd = 0, seen_addr = 0, seen_wr = 0, seen_start = 0, seen_ref = 0;
  int exp_start = 0, exp_ref = 0;
  bit done = 1'b0;
  logic [15:0] exp_rd_idx = '0;

  logic [7:0]  cmd_q[$];
  logic [26:0] addr_q[$];
  logic [15:0] wr_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        seen_cmd++;
        if (cmd_q.size() == 0) chk(1'b0, "R1 unexpected command", {24'h0, cmd_byte}, 32'h0);
        else begin
          logic [7:0] e;
          e = cmd_q.pop_front();
          chk(cmd_byte == e, "R1 command byte", {24'h0, cmd_byte}, {24'h0, e});
        end
      end
      if (addr_valid) begin
        seen_addr++;
        if (addr_q.size() == 0) chk(1'b0, "R3 unexpected address", {5'h0, addr}, 32'h0);
        else begin
          logic [26:0] e;
          e = addr_q.pop_front();
          chk(addr == e, "R2 address", {5'h0, addr}, {5'h0, e});
        end
      end
      if (wr_valid) begin
        seen_wr++;
        if (wr_q.size() == 0) chk(1'b0, "R5 unexpected write", {16'h0, wr_data}, 32'h0);
        else begin
          logic [15:0] e;
          e = wr_q.pop_front();
          chk(wr_data == e, "R4 write word", {16'h0, wr_data}, {16'h0, e});
        end
      end
      if (modify_start) seen_start++;
      if (modify_refused) seen_ref++;
    end
  end

  task automatic wstrobe(input logic c, input logic a, input logic [15:0] v, input int low_cyc);
    @(negedge clk);
    cle = c; ale = a; io_in = v;
    repeat (2) @(negedge clk);
    we_n = 1'b0;
    repeat (low_cyc) @(negedge clk);
    we_n = 1'b1;
    repeat (10) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic send_cmd(input logic [15:0] v, input bit expect_it);
    if (expect_it) cmd_q.push_back(v[7:0]);
    wstrobe(1'b1, 1'b0, v, 6);
  endtask

  task automatic send_addr(input logic [7:0] b);
    wstrobe(1'b0, 1'b1, {8'h00, b}, 6);
  endtask

  task automatic send_full_addr(input logic [7:0] b0, b1, b2, b3);
    logic [31:0] t;
    t = {b3, b2, b1, b0};
    addr_q.push_back(t[26:0]);
    send_addr(b0); send_addr(b1); send_addr(b2); send_addr(b3);
  endtask

  task automatic send_data(input logic [15:0] v, input bit expect_it, input logic [15:0] e);
    if (expect_it) wr_q.push_back(e);
    wstrobe(1'b0, 1'b0, v, 6);
  endtask

  task automatic read_word(input logic [15:0] e, input string tag);
    @(negedge clk);
    re_n = 1'b0;
    repeat (8) @(negedge clk);
    chk(io_oe == 1'b1, "R11 oe during read", {31'h0, io_oe}, 32'h1);
    chk(io_out == e, tag, {16'h0, io_out}, {16'h0, e});
    re_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(io_oe == 1'b0, "R11 oe after read", {31'h0, io_oe}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [15:0] o0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(!cmd_valid && !addr_valid && !wr_valid, "R12 pulses idle", {29'h0, cmd_valid, addr_valid, wr_valid}, 32'h0);
    chk(!modify_start && !modify_refused && !rd_req, "R12 modify/read idle", {29'h0, modify_start, modify_refused, rd_req}, 32'h0);
    chk(addr == '0, "R12 addr zero", {5'h0, addr}, 32'h0);
    chk(io_oe == 1'b0, "R12 oe low", {31'h0, io_oe}, 32'h0);

    ce_n = 1'b0;
    repeat (6) @(negedge clk);

    // R1: command byte from low lane in 16-bit mode
    cfg_x16 = 1'b1;
    send_cmd(16'hAB00, 1'b1);
    cfg_x16 = 1'b0;

    // R2: four-byte address, bits above 26 dropped
    send_full_addr(8'h12, 8'h34, 8'h56, 8'hFF);
    // R3: fifth byte ignored
    c0 = seen_addr;
    send_addr(8'h99);
    chk(seen_addr == c0, "R3 fifth byte no pulse", seen_addr, c0);
    chk(addr == 27'h7563412, "R3 fifth byte no change", {5'h0, addr}, 32'h7563412);

    // R3: partial address dropped by a new command
    send_cmd(16'h0000, 1'b1);
    send_addr(8'h77); send_addr(8'h66);
    send_cmd(16'h0000, 1'b1);
    send_full_addr(8'h01, 8'h02, 8'h03, 8'h04);
    chk(seen_addr == c0 + 1, "R3 count restart", seen_addr, c0 + 1);

    // R7: array reads in 8-bit then 16-bit mode
    read_word({8'h00, exp_rd_idx[7:0]}, "R7 x8 array word"); exp_rd_idx++;
    read_word({8'h00, exp_rd_idx[7:0]}, "R7 x8 array word 2"); exp_rd_idx++;
    cfg_x16 = 1'b1;
    read_word(16'hA000 + exp_rd_idx, "R7 x16 array word"); exp_rd_idx++;
    chk(rd_cnt == exp_rd_idx, "R7 one request per read", {16'h0, rd_cnt}, {16'h0, exp_rd_idx});

    // R8: byte sources, no page-buffer request
    send_cmd(16'hFF70, 1'b1);
    read_word(16'h00E0, "R8 status");
    send_cmd(16'h0090, 1'b1);
    read_word(16'h00AD, "R8 ident");
    send_cmd(16'h007A, 1'b1);
    read_word(16'h0005, "R8 lock");
    chk(rd_cnt == exp_rd_idx, "R8 no request from byte source", {16'h0, rd_cnt}, {16'h0, exp_rd_idx});

    // R6/R4: program accepted, data words in both widths
    send_cmd(16'h0080, 1'b1); exp_start++;
    send_data(16'hBEEF, 1'b1, 16'hBEEF);
    cfg_x16 = 1'b0;
    send_data(16'h12C3, 1'b1, 16'h00C3);
    chk(seen_start == exp_start, "R6 program start", seen_start, exp_start);

    // R5/R6: protect low refuses modify and data
    wp_n = 1'b0;
    repeat (4) @(negedge clk);
    c0 = seen_wr;
    send_cmd(16'h0080, 1'b1); exp_ref++;
    send_data(16'h7777, 1'b0, 16'h0);
    chk(seen_wr == c0, "R5 protected write dropped", seen_wr, c0);
    send_cmd(16'h0060, 1'b1); exp_ref++;
    chk(seen_start == exp_start, "R6 no start while protected", seen_start, exp_start);
    chk(seen_ref == exp_ref, "R6 refusals", seen_ref, exp_ref);
    wp_n = 1'b1;
    repeat (4) @(negedge clk);
    send_cmd(16'h0060, 1'b1); exp_start++;
    chk(seen_start == exp_start, "R6 erase start", seen_start, exp_start);

    // R9: short write and read pulses
    c0 = seen_cmd;
    wstrobe(1'b1, 1'b0, 16'h0055, 2);
    chk(seen_cmd == c0, "R9 write glitch", seen_cmd, c0);
    send_cmd(16'h0000, 1'b1);
    o0 = io_out;
    @(negedge clk); re_n = 1'b0;
    repeat (2) @(negedge clk); re_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(rd_cnt == exp_rd_idx, "R9 read glitch no request", {16'h0, rd_cnt}, {16'h0, exp_rd_idx});
    chk(io_out == o0 && io_oe == 1'b0, "R9 read glitch no word", {15'h0, io_oe, io_out}, {16'h0, o0});

    // R10: deselected device
    ce_n = 1'b1;
    repeat (6) @(negedge clk);
    c0 = seen_cmd;
    send_cmd(16'h0070, 1'b0);
    chk(seen_cmd == c0, "R10 no cycle when deselected", seen_cmd, c0);
    re_n = 1'b0;
    repeat (8) @(negedge clk);
    chk(io_oe == 1'b0, "R10 oe low when deselected", {31'h0, io_oe}, 32'h0);
    chk(rd_cnt == exp_rd_idx, "R10 no read when deselected", {16'h0, rd_cnt}, {16'h0, exp_rd_idx});
    re_n = 1'b1;
    repeat (8) @(negedge clk);

    chk(cmd_q.size() == 0, "R1 all commands seen", cmd_q.size(), 0);
    chk(addr_q.size() == 0, "R2 all addresses seen", addr_q.size(), 0);
    chk(wr_q.size() == 0, "R4 all writes seen", wr_q.size(), 0);
    chk(seen_ref == exp_ref, "R6 final refusals", seen_ref, exp_ref);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule